// File: doc/BRIEF.md
# High-Side Charge Phase Controller

This block sequences the first half of a switching-converter charge cycle as a clocked four-phase handshake machine. A requester raises a charge request; the controller switches the high-side gate drive on, waits for the gate driver to confirm, then arms an over-current wait element and waits for that element to report the current limit. It then switches the gate off, waits for the driver to confirm the off state, and hands control to the low-side phase controller by raising a pass signal.

The pass signal follows a return-to-zero protocol. It is released only after the requester has withdrawn its request and the low-side peer has signalled that it is back in its idle phase. All handshake inputs are asynchronous to the controller clock and go through a configurable synchronizer depth before the state machine sees them. All outputs come straight from flops. A sticky error flag records a wait element that already reports over-current at the moment it is armed.

Top module: `hs_charge_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, hs_gate, ocw_arm, pass_out and proto_err are all 0. The controller starts in its idle phase.
- R2: hs_gate rises only when the synchronized charge request is high and the controller is idle. Toggling hs_gate_ack, ocw_hit or peer_ready while the request is low leaves every output low.
- R3: ocw_arm rises only after the synchronized hs_gate_ack is high while hs_gate is on. ocw_arm is never high while hs_gate is low.
- R4: When ocw_hit is seen high while armed, hs_gate and ocw_arm fall on the same clock edge. This resets the wait element before any later gate switch.
- R5: pass_out rises only after hs_gate is off and the synchronized hs_gate_ack has returned low. hs_gate and pass_out are never high together.
- R6: pass_out falls only when the synchronized charge request is low and peer_ready is high. Until both hold it stays high.
- R7: Every charge request produces exactly one complete cycle. A new cycle starts only after pass_out has fallen and the request is high again, and ocw_arm is low whenever hs_gate rises.
- R8: If ocw_hit is already high (synchronized) on the cycle where ocw_arm is raised, proto_err is set. It stays set until reset, and it is never set in a cycle where ocw_hit was low.
- R9: With SYNC_STAGES synchronizer flops, hs_gate rises on the (SYNC_STAGES+1)-th rising clock edge after chg_req goes high. With the default of 2, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_req | input | 1 | Charge request from the cycle sequencer (four-phase) |
| hs_gate | output | 1 | High-side gate drive enable |
| hs_gate_ack | input | 1 | Gate driver confirmation of the hs_gate level |
| ocw_arm | output | 1 | Arms the over-current wait element |
| ocw_hit | input | 1 | Sanitised over-current indication from the wait element |
| pass_out | output | 1 | Hand-over to the low-side phase (return-to-zero) |
| peer_ready | input | 1 | Low-side peer is back in its idle phase |
| proto_err | output | 1 | Sticky flag: wait element reported a hit when armed |

## Verification
The bench targets four corner cases.
- It holds the pass signal high while only one of its two release conditions is true. A design that ignored peer readiness would issue pass- to a busy low-side controller.
- It holds the gate acknowledge high after the gate goes off. A design that skipped the wait would hand over while the high-side transistor might still conduct.
- It feeds a wait element that is already high at arming. A design without the error flag would silently cut the charge phase to nothing.
- It runs many randomly timed cycles, checking the order of every output edge against the inputs at that moment. This catches missing phases, doubled cycles, and an arm signal left high into the next cycle.

// File: rtl/hs_charge_pkg.sv
package hs_charge_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GUP   = 3'd1,
    PH_ARMED = 3'd2,
    PH_GDN   = 3'd3,
    PH_PASS  = 3'd4
  } hs_phase_e;

  localparam int unsigned HS_N_IN = 4;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q <= '0;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
  import hs_charge_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_q,
  input  logic      ack_q,
  input  logic      hit_q,
  input  logic      rdy_q,
  output hs_phase_e phase_d,
  output logic      arm_start
);
  hs_phase_e phase_q;

  always_comb begin
    phase_d   = phase_q;
    arm_start = 1'b0;
    unique case (phase_q)
      PH_IDLE:  if (req_q) phase_d = PH_GUP;
      PH_GUP:   if (ack_q) begin
                  phase_d   = PH_ARMED;
                  arm_start = 1'b1;
                end
      PH_ARMED: if (hit_q) phase_d = PH_GDN;
      PH_GDN:   if (!ack_q) phase_d = PH_PASS;
      PH_PASS:  if (!req_q && rdy_q) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end
endmodule

// File: rtl/hs_drive_reg.sv
module hs_drive_reg
  import hs_charge_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  hs_phase_e phase_d,
  output logic      gate_q,
  output logic      arm_q,
  output logic      pass_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      arm_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      gate_q <= (phase_d == PH_GUP) || (phase_d == PH_ARMED);
      arm_q  <= (phase_d == PH_ARMED);
      pass_q <= (phase_d == PH_PASS);
    end
  end
endmodule

// File: rtl/hs_arm_guard.sv
module hs_arm_guard (
  input  logic clk,
  input  logic rst,
  input  logic arm_start,
  input  logic hit_q,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst)                   err_q <= 1'b0;
    else if (arm_start && hit_q) err_q <= 1'b1;
  end
endmodule

// File: rtl/hs_charge_ctrl.sv
module hs_charge_ctrl
  import hs_charge_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic chg_req,
  output logic hs_gate,
  input  logic hs_gate_ack,
  output logic ocw_arm,
  input  logic ocw_hit,
  output logic pass_out,
  input  logic peer_ready,
  output logic proto_err
);
  logic [HS_N_IN-1:0] raw_in, sync_in;
  logic req_q, ack_q, hit_q, rdy_q;
  logic arm_start;
  hs_phase_e phase_d;

  assign raw_in = {peer_ready, ocw_hit, hs_gate_ack, chg_req};

  hs_sync #(.WIDTH(HS_N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  assign req_q = sync_in[0];
  assign ack_q = sync_in[1];
  assign hit_q = sync_in[2];
  assign rdy_q = sync_in[3];

  hs_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .req_q(req_q), .ack_q(ack_q), .hit_q(hit_q),
    .rdy_q(rdy_q), .phase_d(phase_d), .arm_start(arm_start)
  );

  hs_drive_reg u_drv (
    .clk(clk), .rst(rst), .phase_d(phase_d),
    .gate_q(hs_gate), .arm_q(ocw_arm), .pass_q(pass_out)
  );

  hs_arm_guard u_guard (
    .clk(clk), .rst(rst), .arm_start(arm_start), .hit_q(hit_q), .err_q(proto_err)
  );
endmodule

// File: rtl/hs_charge_chk.sv
module hs_charge_chk (
  input logic clk,
  input logic rst,
  input logic req_q,
  input logic ack_q,
  input logic hit_q,
  input logic rdy_q,
  input logic hs_gate,
  input logic ocw_arm,
  input logic pass_out,
  input logic proto_err
);
  p_gate_on_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> $past(req_q) && !pass_out);
  p_arm_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ocw_arm) |-> $past(ack_q) && hs_gate);
  p_arm_within_gate_r3: assert property (@(posedge clk) disable iff (rst)
    ocw_arm |-> hs_gate);
  p_off_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_gate) |-> $past(hit_q) && !ocw_arm);
  p_pass_after_ack_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_out) |-> !$past(ack_q) && !hs_gate);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && pass_out));
  p_pass_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pass_out) |-> !$past(req_q) && $past(rdy_q));
  p_arm_low_at_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> !ocw_arm);
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> $rose(ocw_arm) && $past(hit_q));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(proto_err) |-> proto_err);
endmodule

bind hs_charge_ctrl hs_charge_chk u_chk (
  .clk(clk), .rst(rst), .req_q(req_q), .ack_q(ack_q), .hit_q(hit_q),
  .rdy_q(rdy_q), .hs_gate(hs_gate), .ocw_arm(ocw_arm), .pass_out(pass_out),
  .proto_err(proto_err)
);

// File: tb/hs_charge_ctrl_test.sv
module hs_charge_ctrl_test;
  localparam int unsigned S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, ack = 1'b0, hit = 1'b0, rdy = 1'b0;
  logic gate, arm, pass, err;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  hs_charge_ctrl #(.SYNC_STAGES(S)) uut (
    .clk(clk), .rst(rst), .chg_req(req), .hs_gate(gate), .hs_gate_ack(ack),
    .ocw_arm(arm), .ocw_hit(hit), .pass_out(pass), .peer_ready(rdy),
    .proto_err(err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int outs();
    return {28'd0, gate, arm, pass, err};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cyc(3);
    chk(outs() == 0, "R1", "outputs during reset", outs(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == 0, "R1", "outputs after reset", outs(), 0);
  endtask

  // Random environment: gate driver, wait element, requester, low-side peer.
  task automatic run_random(input int n_req);
    int issued = 0, done = 0, idle = 0;
    int d_ack = 0, d_hit = 0, d_req = 0, d_rdy = 0;
    logic pg = 1'b0, pa = 1'b0, pp = 1'b0;
    bit fresh = 1'b0;
    req = 1'b0; ack = 1'b0; hit = 1'b0; rdy = 1'b1;
    while (idle < 60) begin
      @(negedge clk);
      if (gate && !pg) begin
        chk(req && fresh && !arm && !pass, "R2", "gate+ without fresh request", {req, fresh, arm, pass}, 4'b1100);
        fresh = 1'b0;
      end
      if (arm && !pa) chk(gate && ack && !hit, "R3", "arm+ context", {gate, ack, hit}, 3'b110);
      if (!gate && pg) chk(hit && !arm && pa, "R4", "gate- context", {hit, arm, pa}, 3'b101);
      if (arm && !gate) chk(1'b0, "R3", "arm high with gate low", 1, 0);
      if (pass && !pp) chk(!gate && !ack, "R5", "pass+ context", {gate, ack}, 0);
      if (!pass && pp) begin
        chk(!req && rdy, "R6", "pass- context", {req, rdy}, 1);
        done++;
      end
      // gate driver
      if (ack != gate) begin
        if (d_ack == 0) d_ack = 1 + int'($urandom % 4);
        d_ack--;
        if (d_ack == 0) ack = gate;
      end
      // wait element
      if (hit != arm) begin
        if (d_hit == 0) d_hit = 1 + int'($urandom % 6);
        d_hit--;
        if (d_hit == 0) hit = arm;
      end
      // requester
      if (!req && issued < n_req && !pass && !gate && !arm && !hit) begin
        if (d_req == 0) d_req = 1 + int'($urandom % 5);
        d_req--;
        if (d_req == 0) begin req = 1'b1; issued++; fresh = 1'b1; end
      end else if (req && pass) begin
        if (d_req == 0) d_req = 1 + int'($urandom % 5);
        d_req--;
        if (d_req == 0) req = 1'b0;
      end
      // low-side peer
      if (pass && !pp) begin
        rdy = 1'b0; d_rdy = 1 + int'($urandom % 8);
      end else if (!rdy) begin
        d_rdy--;
        if (d_rdy == 0) rdy = 1'b1;
      end
      pg = gate; pa = arm; pp = pass;
      if (issued == n_req && !req && !pass && !gate) idle++;
      else idle = 0;
    end
    chk(done == issued, "R7", "completed cycles", done, issued);
    chk(err == 1'b0, "R8", "no error in clean run", err, 0);
  endtask

  initial begin
    void'($urandom(32'd12345));
    do_reset();

    // R2: inputs other than the request are ignored while idle
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 24; i++) begin
        ack = i[0]; hit = i[1]; rdy = i[2];
        @(negedge clk);
        if (gate || arm || pass) stayed = 1'b0;
      end
      ack = 0; hit = 0; rdy = 0;
      cyc(S + 2);
      chk(stayed && outs() == 0, "R2", "idle ignores non-request inputs", outs(), 0);
    end

    // R9: latency of gate+ from request
    req = 1'b1;
    repeat (S) @(posedge clk);
    @(negedge clk);
    chk(gate == 1'b0, "R9", "gate before latency", gate, 0);
    @(posedge clk); @(negedge clk);
    chk(gate == 1'b1, "R9", "gate at SYNC_STAGES+1 edges", gate, 1);
    cyc(6);
    chk(arm == 1'b0, "R3", "no arm without ack", arm, 0);

    // R3: arm after ack
    ack = 1'b1;
    for (int i = 0; i < 10 && !arm; i++) @(negedge clk);
    chk(arm && gate && !err, "R3", "armed with gate on", {arm, gate, err}, 3'b110);

    // R4: hit drops gate and arm together
    hit = 1'b1;
    for (int i = 0; i < 10 && gate; i++) begin
      @(negedge clk);
      if (arm != gate) chk(1'b0, "R4", "arm and gate split", {arm, gate}, 3);
    end
    chk(!gate && !arm, "R4", "gate and arm off after hit", {gate, arm}, 0);
    hit = 1'b0;

    // R5: pass held back while ack still high
    cyc(10);
    chk(pass == 1'b0, "R5", "pass while ack high", pass, 0);
    ack = 1'b0;
    for (int i = 0; i < 10 && !pass; i++) @(negedge clk);
    chk(pass && !gate, "R5", "pass after ack low", {pass, gate}, 2);

    // R6: pass needs both request low and peer ready
    rdy = 1'b1;
    cyc(10);
    chk(pass == 1'b1, "R6", "pass held while request high", pass, 1);
    req = 1'b0; rdy = 1'b0;
    cyc(10);
    chk(pass == 1'b1, "R6", "pass held while peer busy", pass, 1);
    rdy = 1'b1;
    cyc(S + 2);
    chk(pass == 1'b0, "R6", "pass released", pass, 0);

    // R7: no new cycle without a new request
    cyc(10);
    chk(outs() == 0, "R7", "idle after cycle", outs(), 0);

    // R8: wait element already high when armed
    req = 1'b1;
    for (int i = 0; i < 10 && !gate; i++) @(negedge clk);
    hit = 1'b1;
    cyc(S + 1);
    ack = 1'b1;
    for (int i = 0; i < 10 && !err; i++) @(negedge clk);
    chk(err == 1'b1, "R8", "error on armed-while-hit", err, 1);
    ack = 1'b0; hit = 1'b0;
    for (int i = 0; i < 12 && !pass; i++) @(negedge clk);
    req = 1'b0;
    cyc(S + 4);
    chk(err == 1'b1 && pass == 1'b0, "R8", "error sticky after cycle", {err, pass}, 2);
    do_reset();
    chk(err == 1'b0, "R8", "error cleared by reset", err, 0);

    // random cycles
    run_random(150);
    chk(outs() == 0, "R7", "quiet after random run", outs(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
    $finish;
  end
endmodule